// File: doc/BRIEF.md
# Peripheral Bus Bridge with Per-Transfer Port Sizing

This block takes single 32-bit read and write transfers from a system-side bus and replays them on a slower peripheral bus. The peripheral bus advances on a clock-enable pulse. A mode input sets that pulse to fire on every system clock (full speed) or on every other system clock (half speed). Each peripheral transfer has two phases: an address phase and a data phase.

During the address phase of every transfer, the addressed peripheral reports whether its port is 16 or 32 bits wide. A 32-bit port takes the whole word in one transfer. A 16-bit port gets two transfers: the upper half-word at the base address, then the lower half-word at the base address plus 2. A read from a 16-bit port keeps its first half-word in a holding register and returns the merged word together with a single acknowledge. The acknowledge is a one-cycle pulse.

A small interrupt path carries the peripheral interrupt request lines through two flops before it drives them to the system side.

Top module: `pbus_bridge`

## Requirements
- R1: While reset is low, and on the first cycle after it, `xfer_ack`, `p_sel`, `p_clk_en`, `irq_out` and `xfer_rdata` are all zero.
- R2: `p_port16` is sampled afresh on every transfer, at the enable pulse that ends the first address phase. 0 means a 32-bit port, and the transfer then has a single peripheral beat. 1 means a 16-bit port, and the transfer then has two beats.
- R3: For a 32-bit port, `xfer_ack` is high in the cycle just before the 4th rising edge after the edge that accepted `xfer_start` when `half_speed`=0. With `half_speed`=1 it is high just before the 6th edge.
- R4: For a 16-bit port, that count is 6 edges when `half_speed`=0 and 10 edges when `half_speed`=1.
- R5: On a 16-bit port, the first beat uses the base address and carries bits 31:16 of the word. The second beat uses the base address plus 2 and carries bits 15:0. Half-words travel on bits 15:0 of `p_wdata`/`p_rdata`, and bits 31:16 of `p_rdata` are ignored. `p_addr` stays constant within a beat.
- R6: A read from a 16-bit port returns {first half-word, second half-word} on `xfer_rdata` while `xfer_ack` is high.
- R7: With `half_speed`=1, `p_clk_en` is never high on two consecutive cycles, and a beat spans 4 system clocks. With `half_speed`=0, `p_clk_en` is high on every cycle that `p_sel` is high.
- R8: `xfer_ack` is high for exactly one cycle per transfer.
- R9: `xfer_start` is accepted only when the bridge is idle. A start raised during a transfer, or during its acknowledge cycle, starts no peripheral beat.
- R10: `irq_out` equals `irq_in` as it was two rising edges earlier.
- R11: A read from a 32-bit port returns the full `p_rdata`. A write to a 32-bit port presents the full `xfer_wdata` on `p_wdata` during the data phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_speed | input | 1 | 1: peripheral bus at half rate; change only while idle |
| xfer_start | input | 1 | Start a system transfer (taken when idle) |
| xfer_write | input | 1 | 1 = write, 0 = read |
| xfer_addr | input | 32 | Transfer address |
| xfer_wdata | input | 32 | Write data |
| xfer_ack | output | 1 | One-cycle transfer acknowledge |
| xfer_rdata | output | 32 | Read data, valid with `xfer_ack` |
| p_sel | output | 1 | Peripheral beat in progress |
| p_data_ph | output | 1 | Beat is in its data phase |
| p_clk_en | output | 1 | Peripheral clock-enable pulse |
| p_write | output | 1 | Peripheral write strobe qualifier |
| p_addr | output | 32 | Peripheral beat address |
| p_wdata | output | 32 | Peripheral write data |
| p_rdata | input | 32 | Peripheral read data |
| p_port16 | input | 1 | Addressed port is 16 bits wide |
| irq_in | input | NIRQ | Peripheral interrupt requests |
| irq_out | output | NIRQ | Synchronized interrupt requests |

## Verification
Reads and writes go to both port widths in both speed modes. A word access followed by a split access shows that port size is resampled on each transfer rather than held over. Latency counts separate the four cycle budgets. The beat-address log tells apart a correct half-word order from a swapped one or a missing +2 offset. Merged read data exposes a wrong merge, and the garbage placed in the upper half of a 16-bit port's read bus shows that only bits 15:0 are used. A start raised mid-transfer shows that it is dropped, and stepped interrupt patterns measure the two-edge delay.

// File: rtl/pbb_pkg.sv
package pbb_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;
  localparam int HALF_BYTES = HALF_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_BEAT  = 2'd2,
    ST_ACK   = 2'd3
  } st_e;

  // address of a beat: second half-word sits one half-word above the base
  function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] base,
                                                  input logic second);
    beat_addr = second ? base + ADDR_W'(HALF_BYTES) : base;
  endfunction

  // lane placement of write data for the current beat
  function automatic logic [DATA_W-1:0] beat_wdata(input logic [DATA_W-1:0] word,
                                                   input logic split,
                                                   input logic second);
    if (!split)
      beat_wdata = word;
    else if (!second)
      beat_wdata = {{HALF_W{1'b0}}, word[DATA_W-1:HALF_W]};
    else
      beat_wdata = {{HALF_W{1'b0}}, word[HALF_W-1:0]};
  endfunction

  // merged read word: held upper half and freshly read lower half
  function automatic logic [DATA_W-1:0] merge_halves(input logic [HALF_W-1:0] upper,
                                                     input logic [DATA_W-1:0] rd);
    merge_halves = {upper, rd[HALF_W-1:0]};
  endfunction
endpackage

// File: rtl/pbb_clk_en_gen.sv
module pbb_clk_en_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic half_speed,
  output logic tick
);
  logic ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    ph_q <= 1'b0;
    else if (!run) ph_q <= 1'b0;
    else           ph_q <= ~ph_q;
  end

  assign tick = run & (half_speed ? ph_q : 1'b1);
endmodule

// File: rtl/pbb_ctrl.sv
module pbb_ctrl
  import pbb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic half_speed,
  input  logic start,
  input  logic port16,
  output logic idle,
  output logic busy,
  output logic run,
  output logic phase,
  output logic tick,
  output logic addr_end,
  output logic data_end,
  output logic second,
  output logic split,
  output logic ack
);
  st_e  st_q;
  logic phase_q, second_q, split_q;
  logic last;

  pbb_clk_en_gen u_cen (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .half_speed (half_speed),
    .tick       (tick)
  );

  assign idle     = (st_q == ST_IDLE);
  assign busy     = ~idle;
  assign run      = (st_q == ST_BEAT);
  assign ack      = (st_q == ST_ACK);
  assign phase    = phase_q;
  assign second   = second_q;
  assign split    = split_q;
  assign addr_end = tick & ~phase_q;
  assign data_end = tick & phase_q;
  assign last     = data_end & (second_q | ~split_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      phase_q  <= 1'b0;
      second_q <= 1'b0;
      split_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (start) st_q <= ST_SETUP;
        ST_SETUP: begin
          st_q     <= ST_BEAT;
          phase_q  <= 1'b0;
          second_q <= 1'b0;
          split_q  <= 1'b0;
        end
        ST_BEAT: begin
          if (addr_end) begin
            phase_q <= 1'b1;
            if (!second_q) split_q <= port16;
          end
          if (data_end) begin
            phase_q <= 1'b0;
            if (last) st_q <= ST_ACK;
            else      second_q <= 1'b1;
          end
        end
        ST_ACK: begin
          st_q     <= ST_IDLE;
          second_q <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pbb_irq_sync.sv
module pbb_irq_sync #(
  parameter int NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_in,
  output logic [NIRQ-1:0] stage1,
  output logic [NIRQ-1:0] irq_out
);
  for (genvar i = 0; i < NIRQ; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage1[i]  <= 1'b0;
        irq_out[i] <= 1'b0;
      end else begin
        stage1[i]  <= irq_in[i];
        irq_out[i] <= stage1[i];
      end
    end
  end
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
  import pbb_pkg::*;
#(
  parameter int NIRQ = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_speed,
  input  logic              xfer_start,
  input  logic              xfer_write,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [DATA_W-1:0] xfer_wdata,
  output logic              xfer_ack,
  output logic [DATA_W-1:0] xfer_rdata,
  output logic              p_sel,
  output logic              p_data_ph,
  output logic              p_clk_en,
  output logic              p_write,
  output logic [ADDR_W-1:0] p_addr,
  output logic [DATA_W-1:0] p_wdata,
  input  logic [DATA_W-1:0] p_rdata,
  input  logic              p_port16,
  input  logic [NIRQ-1:0]   irq_in,
  output logic [NIRQ-1:0]   irq_out
);
  // named internal events, visible to the bound checker
  logic idle, busy, run, phase, addr_end, data_end, second, split, accept;
  logic [NIRQ-1:0] irq_stage1;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [HALF_W-1:0] hold_q;
  logic              write_q;

  pbb_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_speed (half_speed),
    .start      (xfer_start),
    .port16     (p_port16),
    .idle       (idle),
    .busy       (busy),
    .run        (run),
    .phase      (phase),
    .tick       (p_clk_en),
    .addr_end   (addr_end),
    .data_end   (data_end),
    .second     (second),
    .split      (split),
    .ack        (xfer_ack)
  );

  assign accept = xfer_start & idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= xfer_addr;
      wdata_q <= xfer_wdata;
      write_q <= xfer_write;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      rdata_q <= '0;
    end else if (data_end && !write_q) begin
      if (!split)       rdata_q <= p_rdata;
      else if (!second) hold_q  <= p_rdata[HALF_W-1:0];
      else              rdata_q <= merge_halves(hold_q, p_rdata);
    end
  end

  assign xfer_rdata = rdata_q;
  assign p_sel      = run;
  assign p_data_ph  = run & phase;
  assign p_write    = run & write_q;
  assign p_addr     = beat_addr(addr_q, second);
  assign p_wdata    = beat_wdata(wdata_q, split, second);

  pbb_irq_sync #(.NIRQ(NIRQ)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .stage1  (irq_stage1),
    .irq_out (irq_out)
  );
endmodule

// File: rtl/pbus_bridge_chk.sv
module pbus_bridge_chk #(
  parameter int NIRQ = 8,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              half_speed,
  input logic              xfer_start,
  input logic              xfer_ack,
  input logic              p_sel,
  input logic              p_clk_en,
  input logic [ADDR_W-1:0] p_addr,
  input logic              busy,
  input logic              data_end,
  input logic [NIRQ-1:0]   irq_in,
  input logic [NIRQ-1:0]   irq_stage1,
  input logic [NIRQ-1:0]   irq_out
);
  logic [1:0] seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n)            seen_q <= 2'd0;
    else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
  end

  a_r8_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |=> !xfer_ack);

  a_r9_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q != 2'd0 && $rose(busy)) |-> $past(xfer_start));

  a_r7_half_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (half_speed && p_clk_en) |=> !p_clk_en);

  a_r7_full_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_speed && p_sel) |-> p_clk_en);

  a_r3_ack_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q != 2'd0 && xfer_ack) |-> $past(data_end));

  a_r5_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q != 2'd0 && p_sel && $past(p_sel) && !$past(data_end)) |-> $stable(p_addr));

  a_r10_irq_first: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 2'd3) |-> (irq_stage1 == $past(irq_in)));

  a_r10_irq_second: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 2'd3) |-> (irq_out == $past(irq_stage1)));
endmodule

bind pbus_bridge pbus_bridge_chk #(.NIRQ(NIRQ), .ADDR_W(pbb_pkg::ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .half_speed (half_speed),
  .xfer_start (xfer_start),
  .xfer_ack   (xfer_ack),
  .p_sel      (p_sel),
  .p_clk_en   (p_clk_en),
  .p_addr     (p_addr),
  .busy       (busy),
  .data_end   (data_end),
  .irq_in     (irq_in),
  .irq_stage1 (irq_stage1),
  .irq_out    (irq_out)
);

// File: tb/pbus_bridge_tb_top.sv
`timescale 1ns/1ps
module pbus_bridge_tb_top;
  localparam int NIRQ = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        half_speed = 1'b0;
  logic        xfer_start = 1'b0;
  logic        xfer_write = 1'b0;
  logic [31:0] xfer_addr = '0;
  logic [31:0] xfer_wdata = '0;
  logic        xfer_ack;
  logic [31:0] xfer_rdata;
  logic        p_sel, p_data_ph, p_clk_en, p_write;
  logic [31:0] p_addr, p_wdata, p_rdata;
  logic        p_port16;
  logic [NIRQ-1:0] irq_in = '0;
  logic [NIRQ-1:0] irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pbus_bridge #(.NIRQ(NIRQ)) dut_i (.*);

  // ---- peripheral model: addr bit 12 set selects a 16-bit port ----
  logic [31:0] m32 [32];
  logic [15:0] m16 [32];

  function automatic logic [31:0] w32(input int i);
    return 32'h1000_0000 + 32'(i) * 32'h0101_0101;
  endfunction
  function automatic logic [15:0] h16(input int i);
    return 16'hA000 + 16'(i) * 16'h0111;
  endfunction

  assign p_port16 = p_addr[12];
  assign p_rdata  = p_addr[12] ? {16'hC0DE, m16[p_addr[5:1]]} : m32[p_addr[6:2]];

  // bench-side monitors
  int beat_n = 0, en_n = 0, sel_rises = 0, b2b = 0;
  logic prev_en = 1'b0, prev_sel = 1'b0;
  logic [31:0] beat_log [16];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin
        m32[i] <= w32(i);
        m16[i] <= h16(i);
      end
    end else if (p_clk_en && p_data_ph) begin
      beat_log[beat_n[3:0]] <= p_addr;
      beat_n <= beat_n + 1;
      if (p_write) begin
        if (p_addr[12]) m16[p_addr[5:1]] <= p_wdata[15:0];
        else            m32[p_addr[6:2]] <= p_wdata;
      end
    end
    if (p_clk_en) en_n <= en_n + 1;
    if (p_clk_en && prev_en && half_speed) b2b <= b2b + 1;
    if (p_sel && !prev_sel) sel_rises <= sel_rises + 1;
    prev_en  <= p_clk_en;
    prev_sel <= p_sel;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one system transfer; returns read data and latency in edges
  task automatic run_xfer(input logic wr, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int lat, output bit ack_one);
    bit seen = 0;
    @(negedge clk);
    xfer_start = 1'b1; xfer_write = wr; xfer_addr = a; xfer_wdata = d;
    @(posedge clk);
    lat = 0; rd = '0;
    while (!seen && lat < 40) begin
      @(negedge clk);
      if (lat == 0) xfer_start = 1'b0;
      lat++;
      if (xfer_ack) begin seen = 1; rd = xfer_rdata; end
    end
    @(negedge clk);
    ack_one = seen && !xfer_ack;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!xfer_ack && !p_sel && !p_clk_en && irq_out == '0 && xfer_rdata == '0,
          "R1 reset outputs", {xfer_ack, p_sel, p_clk_en, 29'd0} | xfer_rdata, 32'h0);
  endtask

  task automatic t_word(input logic hs);
    logic [31:0] rd; int lat; bit one; int b0, e0;
    half_speed = hs;
    b0 = beat_n; e0 = en_n;
    run_xfer(1'b0, 32'h0000_0010, '0, rd, lat, one);
    check(rd == w32(4), "R11 word read data", rd, w32(4));
    check(lat == (hs ? 6 : 4), "R3 word latency", 32'(lat), hs ? 6 : 4);
    check(beat_n - b0 == 1, "R2 word one beat", 32'(beat_n - b0), 1);
    check(en_n - e0 == 2, "R7 word enable pulses", 32'(en_n - e0), 2);
    check(one, "R8 ack single cycle", 32'(one), 1);
    run_xfer(1'b1, 32'h0000_0014 + (hs ? 32'h8 : 32'h0), 32'hCAFE_F00D ^ {31'd0, hs}, rd, lat, one);
    check(m32[hs ? 7 : 5] == (32'hCAFE_F00D ^ {31'd0, hs}), "R11 word write data",
          m32[hs ? 7 : 5], 32'hCAFE_F00D ^ {31'd0, hs});
    check(lat == (hs ? 6 : 4), "R3 word write latency", 32'(lat), hs ? 6 : 4);
  endtask

  task automatic t_split(input logic hs);
    logic [31:0] rd, exp; int lat; bit one; int b0, e0;
    half_speed = hs;
    b0 = beat_n; e0 = en_n;
    exp = {h16(4), h16(5)};
    run_xfer(1'b0, 32'h0000_1008, '0, rd, lat, one);
    check(rd == exp, "R6 split read merge", rd, exp);
    check(lat == (hs ? 10 : 6), "R4 split latency", 32'(lat), hs ? 10 : 6);
    check(beat_n - b0 == 2, "R2 split two beats", 32'(beat_n - b0), 2);
    check(beat_log[b0[3:0]] == 32'h1008, "R5 first beat address", beat_log[b0[3:0]], 32'h1008);
    check(beat_log[4'(b0 + 1)] == 32'h100A, "R5 second beat address", beat_log[4'(b0 + 1)], 32'h100A);
    check(en_n - e0 == 4, "R7 split enable pulses", 32'(en_n - e0), 4);
    check(one, "R8 split ack single cycle", 32'(one), 1);
    run_xfer(1'b1, hs ? 32'h0000_1018 : 32'h0000_1010, 32'h1234_ABCD, rd, lat, one);
    check(m16[hs ? 12 : 8] == 16'h1234, "R5 upper half first", 32'(m16[hs ? 12 : 8]), 32'h1234);
    check(m16[hs ? 13 : 9] == 16'hABCD, "R5 lower half second", 32'(m16[hs ? 13 : 9]), 32'hABCD);
    check(lat == (hs ? 10 : 6), "R4 split write latency", 32'(lat), hs ? 10 : 6);
  endtask

  task automatic t_busy;
    int b0, s0, guard;
    half_speed = 1'b1;
    b0 = beat_n; s0 = sel_rises;
    @(negedge clk);
    xfer_start = 1'b1; xfer_write = 1'b0; xfer_addr = 32'h0000_0020;
    @(negedge clk); xfer_start = 1'b0;
    @(negedge clk); xfer_start = 1'b1; xfer_addr = 32'h0000_1000;
    @(negedge clk); xfer_start = 1'b0;
    guard = 0;
    while (!xfer_ack && guard < 40) begin @(negedge clk); guard++; end
    xfer_start = 1'b1;                 // raised during the acknowledge cycle
    @(negedge clk); xfer_start = 1'b0;
    repeat (12) @(negedge clk);
    check(sel_rises - s0 == 1, "R9 one transfer only", 32'(sel_rises - s0), 1);
    check(beat_n - b0 == 1, "R9 no extra beat", 32'(beat_n - b0), 1);
    check(beat_log[b0[3:0]] == 32'h20, "R9 original address kept", beat_log[b0[3:0]], 32'h20);
  endtask

  task automatic t_irq;
    @(negedge clk); irq_in = 8'hA5;
    @(negedge clk);
    check(irq_out == 8'h00, "R10 irq after one edge", 32'(irq_out), 0);
    @(negedge clk);
    check(irq_out == 8'hA5, "R10 irq after two edges", 32'(irq_out), 32'hA5);
    irq_in = 8'h3C;
    @(negedge clk);
    check(irq_out == 8'hA5, "R10 irq holds one edge", 32'(irq_out), 32'hA5);
    @(negedge clk);
    check(irq_out == 8'h3C, "R10 irq new pattern", 32'(irq_out), 32'h3C);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_word(1'b0);
    t_split(1'b0);
    t_word(1'b0);
    t_word(1'b1);
    t_split(1'b1);
    check(b2b == 0, "R7 half speed spacing", 32'(b2b), 0);
    t_busy;
    t_irq;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule